// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the pixel and line timing for a progressive video raster. Two counters, one for pixels within a line and one for lines within a frame, step on every clock while the generator runs. From their values the block decodes horizontal and vertical sync pulses with selectable polarity, horizontal and vertical blank flags, and a data-enable for the visible area. It also exposes the current position, a frame counter, and a one-cycle line interrupt.

The timing is set from per-axis quantities: total, addressable size, leading and trailing borders, front porch and sync width. Both sync pulses start at count zero. The visible window is therefore derived. It opens after the sync pulse and the back porch, and it closes one front porch before the end of the axis. All configuration, including the request to blank pixel data, is held in a shadow stage. That stage takes new values only while the generator is idle or at the last pixel of a frame. When the blank request is in force, the pixel path outputs a fixed three-component fill colour instead of the incoming pixel.

Clearing the run enable does not stop the raster at once. The frame continues until the end of the first vertical blank line. After that the counters rest at zero.

Top module: `raster_timing_gen`

## Requirements
- R1: While running, `h_pos` counts 0 to `h_total`-1 and wraps to 0. `v_pos` advances by one at each horizontal wrap, and wraps to 0 after line `v_total`-1.
- R2: The horizontal sync is active while `h_pos` < `h_sync_w`. The vertical sync is active while `v_pos` < `v_sync_w`.
- R3: The visible span of an axis runs from first = total − front − active − lead − trail up to, but not including, last = total − front. `hblank` and `vblank` are 1 outside their spans and are 1 while idle. `de` is 1 only when both axes are inside their spans.
- R4: A polarity bit of 0 gives an active-high sync and 1 gives an active-low sync. While idle, each sync output sits at its inactive level.
- R5: A vertical front porch of 0 is treated as 1 line, so line `v_total`-1 is always blanked.
- R6: `vline_irq` is 1 for exactly the cycle at `h_pos`=0 of line L = vfirst − `irq_lead` + 1. If that value is negative, L = 0.
- R7: `frame_cnt` increments by one at `h_pos`=0 of the first vertical blank line (line vlast). It wraps modulo 2^FRAME_W and holds while idle.
- R8: When the blank state is in force, `blanked`=1 and `pix_out` = {`fill_cr`, `fill_y`, `fill_cb`}, with Cb/B in the least significant COMP_W bits, Y/G in the middle and Cr/R at the top. Otherwise `pix_out` = `pix_in` and `blanked`=0.
- R9: While idle, a high `run_en` starts the raster at position 0,0 on the next cycle. If `run_en` is low while running, the raster runs to the last pixel of line vlast and then goes idle, with both positions at 0 and `de` low.
- R10: Timing inputs, polarities, `irq_lead` and `blank_req` are sampled every idle cycle and at the last pixel of each frame. Changes made mid-frame have no effect until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable |
| h_total | input | 13 | Pixels per line |
| h_active | input | 13 | Addressable pixels |
| h_lead | input | 13 | Left border pixels |
| h_trail | input | 13 | Right border pixels |
| h_front | input | 13 | Horizontal front porch |
| h_sync_w | input | 13 | Horizontal sync width |
| v_total | input | 13 | Lines per frame |
| v_active | input | 13 | Addressable lines |
| v_lead | input | 13 | Top border lines |
| v_trail | input | 13 | Bottom border lines |
| v_front | input | 13 | Vertical front porch |
| v_sync_w | input | 13 | Vertical sync width |
| irq_lead | input | 13 | Lines before the visible start at which the interrupt fires |
| h_pol | input | 1 | Horizontal sync polarity, 1 = active low |
| v_pol | input | 1 | Vertical sync polarity, 1 = active low |
| blank_req | input | 1 | Request to replace pixel data with the fill colour |
| fill_cb | input | COMP_W | Fill colour Cb/B component |
| fill_y | input | COMP_W | Fill colour Y/G component |
| fill_cr | input | COMP_W | Fill colour Cr/R component |
| pix_in | input | 3*COMP_W | Incoming pixel |
| pix_out | output | 3*COMP_W | Outgoing pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| de | output | 1 | Data enable |
| h_pos | output | 13 | Current pixel count |
| v_pos | output | 13 | Current line count |
| frame_cnt | output | FRAME_W | Frame counter |
| vline_irq | output | 1 | Line interrupt pulse |
| blanked | output | 1 | Blank state in force |
| running | output | 1 | Raster running |

## Verification
If a counter or the run state goes wrong, `h_pos` and `v_pos` show it in the same cycle. Sync, blank and enable then disagree with the reference within one line. A wrong shadow load shows up one frame late, as a sync edge or blank flag at the old or new position. The bench therefore makes a frame-spanning comparison against a behavioural model on every clock. It adds directed samples on the line just before and just after a mid-frame reconfiguration. A wrong stop point shows at the ports as a `running` fall on the wrong line, or as a frame count that keeps moving while idle.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;

    localparam int unsigned AXIS_W = 13;

    typedef logic [AXIS_W-1:0] pos_t;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    // Raw per-axis quantities as supplied at the block boundary.
    typedef struct packed {
        pos_t total;
        pos_t active;
        pos_t lead;
        pos_t trail;
        pos_t front;
        pos_t sync_w;
    } axis_raw_t;

    // Derived compare points used by the counters and decoders.
    typedef struct packed {
        pos_t last;       // total - 1
        pos_t sync_end;   // sync active below this
        pos_t vis_first;  // first visible count
        pos_t vis_last;   // first count after the visible span
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t h;
        axis_cfg_t v;
        pos_t      irq_line;
        logic      h_pol;
        logic      v_pol;
        logic      blank;
    } frame_cfg_t;

    function automatic axis_cfg_t derive_axis(input axis_raw_t r, input logic min_one_front);
        pos_t      fp;
        axis_cfg_t c;
        fp          = (min_one_front && (r.front == '0)) ? pos_t'(1) : r.front;
        c.last      = r.total - pos_t'(1);
        c.sync_end  = r.sync_w;
        c.vis_last  = r.total - fp;
        c.vis_first = c.vis_last - r.active - r.lead - r.trail;
        return c;
    endfunction

    function automatic pos_t irq_line_of(input pos_t vis_first, input pos_t lead_lines);
        logic [AXIS_W:0] reach;
        logic [AXIS_W:0] diff;
        reach = {1'b0, vis_first} + {{AXIS_W{1'b0}}, 1'b1};
        diff  = reach - {1'b0, lead_lines};
        return ({1'b0, lead_lines} > reach) ? '0 : diff[AXIS_W-1:0];
    endfunction

    function automatic logic in_span(input pos_t p, input pos_t lo, input pos_t hi);
        return (p >= lo) && (p < hi);
    endfunction

endpackage

// File: rtl/raster_cfg_stage.sv
`timescale 1ns/1ps
module raster_cfg_stage
    import raster_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  axis_raw_t  h_raw,
    input  axis_raw_t  v_raw,
    input  pos_t       irq_lead,
    input  logic       h_pol,
    input  logic       v_pol,
    input  logic       blank_req,
    output frame_cfg_t active_cfg
);

    frame_cfg_t next_cfg;

    always_comb begin
        next_cfg.h        = derive_axis(h_raw, 1'b0);
        next_cfg.v        = derive_axis(v_raw, 1'b1);
        next_cfg.irq_line = irq_line_of(next_cfg.v.vis_first, irq_lead);
        next_cfg.h_pol    = h_pol;
        next_cfg.v_pol    = v_pol;
        next_cfg.blank    = blank_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_cfg <= '0;
        end else if (load) begin
            active_cfg <= next_cfg;
        end
    end

endmodule

// File: rtl/raster_core.sv
`timescale 1ns/1ps
module raster_core
    import raster_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  axis_cfg_t h_cfg,
    input  axis_cfg_t v_cfg,
    input  pos_t      irq_line,
    input  logic      h_pol,
    input  logic      v_pol,
    output logic      running,
    output pos_t      h_pos,
    output pos_t      v_pos,
    output logic      cfg_load,
    output logic      vblank_entry,
    output logic      hsync,
    output logic      vsync,
    output logic      hblank,
    output logic      vblank,
    output logic      de,
    output logic      vline_irq
);

    localparam int unsigned N_AXES = 2;

    scan_state_e state;
    logic        line_end;
    logic        frame_end;
    logic        stop_now;
    pos_t        v_next;

    assign running      = (state == SCAN_RUN);
    assign line_end     = running && (h_pos == h_cfg.last);
    assign v_next       = (v_pos == v_cfg.last) ? '0 : v_pos + 1'b1;
    assign frame_end    = line_end && (v_pos == v_cfg.last);
    // The clamped front porch keeps vis_last at or below last, so this line is always reached.
    assign stop_now     = line_end && !enable && (v_pos == v_cfg.vis_last);
    assign vblank_entry = line_end && (v_next == v_cfg.vis_last);
    assign cfg_load     = !running || frame_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SCAN_IDLE;
            h_pos <= '0;
            v_pos <= '0;
        end else begin
            case (state)
                SCAN_IDLE: begin
                    h_pos <= '0;
                    v_pos <= '0;
                    if (enable) state <= SCAN_RUN;
                end
                default: begin
                    if (stop_now) begin
                        state <= SCAN_IDLE;
                        h_pos <= '0;
                        v_pos <= '0;
                    end else if (line_end) begin
                        h_pos <= '0;
                        v_pos <= v_next;
                    end else begin
                        h_pos <= h_pos + 1'b1;
                    end
                end
            endcase
        end
    end

    // Per-axis decode: index 0 horizontal, index 1 vertical.
    pos_t             pos_a [N_AXES];
    axis_cfg_t        cfg_a [N_AXES];
    logic [N_AXES-1:0] sync_on;
    logic [N_AXES-1:0] vis_on;

    assign pos_a[0] = h_pos;
    assign pos_a[1] = v_pos;
    assign cfg_a[0] = h_cfg;
    assign cfg_a[1] = v_cfg;

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        assign sync_on[g] = running && (pos_a[g] < cfg_a[g].sync_end);
        assign vis_on[g]  = running && in_span(pos_a[g], cfg_a[g].vis_first, cfg_a[g].vis_last);
    end

    assign hsync     = sync_on[0] ^ h_pol;
    assign vsync     = sync_on[1] ^ v_pol;
    assign hblank    = !vis_on[0];
    assign vblank    = !vis_on[1];
    assign de        = &vis_on;
    assign vline_irq = running && (h_pos == '0) && (v_pos == irq_line);

endmodule

// File: rtl/raster_pix_mux.sv
`timescale 1ns/1ps
module raster_pix_mux #(
    parameter int unsigned COMP_W = 10
) (
    input  logic                  blank,
    input  logic [3*COMP_W-1:0]   pix_in,
    input  logic [COMP_W-1:0]     fill_cb,
    input  logic [COMP_W-1:0]     fill_y,
    input  logic [COMP_W-1:0]     fill_cr,
    output logic [3*COMP_W-1:0]   pix_out
);

    localparam int unsigned N_COMP = 3;

    logic [COMP_W-1:0] fill_a [N_COMP];

    assign fill_a[0] = fill_cb;
    assign fill_a[1] = fill_y;
    assign fill_a[2] = fill_cr;

    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
        assign pix_out[c*COMP_W +: COMP_W] = blank ? fill_a[c] : pix_in[c*COMP_W +: COMP_W];
    end

endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned COMP_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_en,
    input  logic [AXIS_W-1:0]    h_total,
    input  logic [AXIS_W-1:0]    h_active,
    input  logic [AXIS_W-1:0]    h_lead,
    input  logic [AXIS_W-1:0]    h_trail,
    input  logic [AXIS_W-1:0]    h_front,
    input  logic [AXIS_W-1:0]    h_sync_w,
    input  logic [AXIS_W-1:0]    v_total,
    input  logic [AXIS_W-1:0]    v_active,
    input  logic [AXIS_W-1:0]    v_lead,
    input  logic [AXIS_W-1:0]    v_trail,
    input  logic [AXIS_W-1:0]    v_front,
    input  logic [AXIS_W-1:0]    v_sync_w,
    input  logic [AXIS_W-1:0]    irq_lead,
    input  logic                 h_pol,
    input  logic                 v_pol,
    input  logic                 blank_req,
    input  logic [COMP_W-1:0]    fill_cb,
    input  logic [COMP_W-1:0]    fill_y,
    input  logic [COMP_W-1:0]    fill_cr,
    input  logic [3*COMP_W-1:0]  pix_in,
    output logic [3*COMP_W-1:0]  pix_out,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 hblank,
    output logic                 vblank,
    output logic                 de,
    output logic [AXIS_W-1:0]    h_pos,
    output logic [AXIS_W-1:0]    v_pos,
    output logic [FRAME_W-1:0]   frame_cnt,
    output logic                 vline_irq,
    output logic                 blanked,
    output logic                 running
);

    axis_raw_t  h_raw;
    axis_raw_t  v_raw;
    frame_cfg_t act_cfg;
    logic       cfg_load;
    logic       vblank_entry;

    assign h_raw = '{total: h_total, active: h_active, lead: h_lead,
                     trail: h_trail, front: h_front, sync_w: h_sync_w};
    assign v_raw = '{total: v_total, active: v_active, lead: v_lead,
                     trail: v_trail, front: v_front, sync_w: v_sync_w};

    raster_cfg_stage u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load       (cfg_load),
        .h_raw      (h_raw),
        .v_raw      (v_raw),
        .irq_lead   (irq_lead),
        .h_pol      (h_pol),
        .v_pol      (v_pol),
        .blank_req  (blank_req),
        .active_cfg (act_cfg)
    );

    raster_core u_core (
        .clk          (clk),
        .rst          (rst),
        .enable       (run_en),
        .h_cfg        (act_cfg.h),
        .v_cfg        (act_cfg.v),
        .irq_line     (act_cfg.irq_line),
        .h_pol        (act_cfg.h_pol),
        .v_pol        (act_cfg.v_pol),
        .running      (running),
        .h_pos        (h_pos),
        .v_pos        (v_pos),
        .cfg_load     (cfg_load),
        .vblank_entry (vblank_entry),
        .hsync        (hsync),
        .vsync        (vsync),
        .hblank       (hblank),
        .vblank       (vblank),
        .de           (de),
        .vline_irq    (vline_irq)
    );

    raster_pix_mux #(.COMP_W(COMP_W)) u_pix (
        .blank   (act_cfg.blank),
        .pix_in  (pix_in),
        .fill_cb (fill_cb),
        .fill_y  (fill_y),
        .fill_cr (fill_cr),
        .pix_out (pix_out)
    );

    assign blanked = act_cfg.blank;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
        end else if (vblank_entry) begin
            frame_cnt <= frame_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/raster_timing_gen_chk.sv
`timescale 1ns/1ps
module raster_timing_gen_chk
    import raster_pkg::*;
#(
    parameter int unsigned FRAME_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               run_en,
    input logic               running,
    input pos_t               h_pos,
    input pos_t               v_pos,
    input logic               de,
    input logic               vblank,
    input logic [FRAME_W-1:0] frame_cnt,
    input logic               vline_irq
);

    AST_IDLE_AT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        !running |-> (h_pos == '0 && v_pos == '0 && !de)); // R9

    AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && h_pos != '0) |-> (h_pos == $past(h_pos) + 1'b1)); // R1

    AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && h_pos != '0) |-> $stable(v_pos)); // R1

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (frame_cnt != $past(frame_cnt)) |-> (frame_cnt == $past(frame_cnt) + 1'b1 && h_pos == '0 && vblank)); // R7

    AST_IRQ_LINE_START: assert property (@(posedge clk) disable iff (rst)
        vline_irq |-> (running && h_pos == '0)); // R6

    AST_STOP_NEEDS_DISABLE: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> !$past(run_en)); // R9

endmodule

bind raster_timing_gen raster_timing_gen_chk #(.FRAME_W(FRAME_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .running   (running),
    .h_pos     (h_pos),
    .v_pos     (v_pos),
    .de        (de),
    .vblank    (vblank),
    .frame_cnt (frame_cnt),
    .vline_irq (vline_irq)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
    import raster_pkg::*;

    localparam int FW = 4;
    localparam int CW = 10;
    localparam int CYCLE_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    pos_t h_total, h_active, h_lead, h_trail, h_front, h_sync_w;
    pos_t v_total, v_active, v_lead, v_trail, v_front, v_sync_w;
    pos_t irq_lead;
    logic h_pol = 1'b0, v_pol = 1'b0, blank_req = 1'b0;
    logic [CW-1:0] fill_cb = 10'h0a1, fill_y = 10'h155, fill_cr = 10'h2c3;
    logic [3*CW-1:0] pix_in = '0;
    logic [3*CW-1:0] pix_out;
    logic hsync, vsync, hblank, vblank, de, vline_irq, blanked, running;
    pos_t h_pos, v_pos;
    logic [FW-1:0] frame_cnt;

    always #10 clk = ~clk;

    raster_timing_gen #(.FRAME_W(FW), .COMP_W(CW)) dut_i (
        .clk(clk), .rst(rst), .run_en(run_en),
        .h_total(h_total), .h_active(h_active), .h_lead(h_lead), .h_trail(h_trail),
        .h_front(h_front), .h_sync_w(h_sync_w),
        .v_total(v_total), .v_active(v_active), .v_lead(v_lead), .v_trail(v_trail),
        .v_front(v_front), .v_sync_w(v_sync_w),
        .irq_lead(irq_lead), .h_pol(h_pol), .v_pol(v_pol), .blank_req(blank_req),
        .fill_cb(fill_cb), .fill_y(fill_y), .fill_cr(fill_cr), .pix_in(pix_in),
        .pix_out(pix_out), .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .de(de), .h_pos(h_pos), .v_pos(v_pos), .frame_cnt(frame_cnt),
        .vline_irq(vline_irq), .blanked(blanked), .running(running)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Reference model state
    int m_run, m_h, m_v, m_fc, m_blank;
    int m_htm1, m_hse, m_hbe, m_hbs, m_hpol;
    int m_vtm1, m_vse, m_vbe, m_vbs, m_vpol, m_vint;

    task automatic model_load();
        int vfp;
        m_htm1 = int'(h_total) - 1;
        m_hse  = int'(h_sync_w);
        m_hbs  = int'(h_total) - int'(h_front);
        m_hbe  = m_hbs - int'(h_active) - int'(h_lead) - int'(h_trail);
        vfp    = (int'(v_front) < 1) ? 1 : int'(v_front);
        m_vtm1 = int'(v_total) - 1;
        m_vse  = int'(v_sync_w);
        m_vbs  = int'(v_total) - vfp;
        m_vbe  = m_vbs - int'(v_active) - int'(v_lead) - int'(v_trail);
        m_vint = m_vbe - int'(irq_lead) + 1;
        if (m_vint < 0) m_vint = 0;
        m_hpol  = int'(h_pol);
        m_vpol  = int'(v_pol);
        m_blank = int'(blank_req);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_h = 0; m_v = 0; m_fc = 0; m_blank = 0;
            m_htm1 = 0; m_hse = 0; m_hbe = 0; m_hbs = 0; m_hpol = 0;
            m_vtm1 = 0; m_vse = 0; m_vbe = 0; m_vbs = 0; m_vpol = 0; m_vint = 0;
        end else if (m_run == 0) begin
            m_h = 0; m_v = 0;
            m_run = run_en ? 1 : 0;
            model_load();
        end else begin
            int vn;
            vn = (m_v == m_vtm1) ? 0 : m_v + 1;
            if (m_h == m_htm1) begin
                if (vn == m_vbs) m_fc = (m_fc + 1) % (1 << FW);
                if (!run_en && m_v == m_vbs) begin
                    m_run = 0; m_h = 0; m_v = 0;
                end else begin
                    int endf;
                    endf = (m_v == m_vtm1) ? 1 : 0;
                    m_h = 0;
                    m_v = vn;
                    if (endf != 0) model_load();
                end
            end else begin
                m_h = m_h + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic compare_all();
        int hs, vs, hb, vb, e_de, irq;
        logic [3*CW-1:0] e_pix;
        hs   = (m_run != 0 && m_h < m_hse) ? 1 : 0;
        vs   = (m_run != 0 && m_v < m_vse) ? 1 : 0;
        hb   = (m_run != 0 && m_h >= m_hbe && m_h < m_hbs) ? 0 : 1;
        vb   = (m_run != 0 && m_v >= m_vbe && m_v < m_vbs) ? 0 : 1;
        e_de = (hb == 0 && vb == 0) ? 1 : 0;
        irq  = (m_run != 0 && m_h == 0 && m_v == m_vint) ? 1 : 0;
        e_pix = (m_blank != 0) ? {fill_cr, fill_y, fill_cb} : pix_in;
        chk("R9", "running", running, m_run);
        chk("R1", "h_pos", h_pos, m_h);
        chk("R1", "v_pos", v_pos, m_v);
        chk("R2/R4", "hsync", hsync, hs ^ m_hpol);
        chk("R2/R4", "vsync", vsync, vs ^ m_vpol);
        chk("R3", "hblank", hblank, hb);
        chk("R3", "vblank", vblank, vb);
        chk("R3", "de", de, e_de);
        chk("R6", "vline_irq", vline_irq, irq);
        chk("R7", "frame_cnt", frame_cnt, m_fc);
        chk("R8", "blanked", blanked, m_blank);
        chk("R8", "pix_out", pix_out, e_pix);
    endtask

    task automatic step();
        @(posedge clk);
        #5;
        cyc++;
        compare_all();
        pix_in = pix_in + 30'h0123_4567;
        if (cyc > CYCLE_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: got %0d cycles expected at most %0d", cyc, CYCLE_LIMIT);
            finish_run();
        end
    endtask

    task automatic wait_pos(input int hp, input int vp);
        do step(); while (!(running && int'(h_pos) == hp && int'(v_pos) == vp));
    endtask

    task automatic set_cfg_a();
        h_total = 20; h_active = 8; h_lead = 1; h_trail = 1; h_front = 3; h_sync_w = 2;
        v_total = 12; v_active = 6; v_lead = 0; v_trail = 1; v_front = 2; v_sync_w = 1;
        irq_lead = 2; h_pol = 1'b0; v_pol = 1'b0; blank_req = 1'b0;
    endtask

    task automatic set_cfg_b();
        h_sync_w = 4; h_pol = 1'b1; v_pol = 1'b1; blank_req = 1'b1;
        v_front = 0; irq_lead = 10;
    endtask

    initial begin
        longint fc_hold;
        set_cfg_a();
        repeat (3) step();
        // Reset state
        chk("R9", "reset running", running, 0);
        chk("R1", "reset h_pos", h_pos, 0);
        chk("R1", "reset v_pos", v_pos, 0);
        chk("R7", "reset frame_cnt", frame_cnt, 0);
        chk("R3", "reset de", de, 0);
        rst = 1'b0;
        step();
        run_en = 1'b1;
        step();
        chk("R9", "start running", running, 1);
        chk("R9", "start h_pos", h_pos, 0);
        chk("R9", "start v_pos", v_pos, 0);
        // Config A: vfirst 3, irq line 2, vlast 10
        wait_pos(0, 2);
        chk("R6", "irq at line 2", vline_irq, 1);
        wait_pos(1, 6);
        chk("R4", "active-high hsync", hsync, 1);
        wait_pos(0, 10);
        chk("R7", "first vblank entry", frame_cnt, 1);
        wait_pos(0, 5);
        set_cfg_b();
        wait_pos(1, 6);
        chk("R10", "hsync unchanged mid-frame", hsync, 1);
        chk("R10", "blank unchanged mid-frame", blanked, 0);
        wait_pos(1, 6);
        chk("R10", "hsync after frame start", hsync, 0);
        chk("R8", "blanked after frame start", blanked, 1);
        chk("R8", "fill colour order", pix_out, {fill_cr, fill_y, fill_cb});
        // Config B: vertical front porch 0 clamped to 1, vfirst 4, vlast 11
        wait_pos(7, 11);
        chk("R5", "last line blanked", vblank, 1);
        wait_pos(7, 10);
        chk("R5", "line before last visible", de, 1);
        wait_pos(0, 0);
        chk("R6", "negative irq line clamps to 0", vline_irq, 1);
        wait_pos(5, 2);
        run_en = 1'b0;
        do step(); while (running);
        chk("R9", "stopped h_pos", h_pos, 0);
        chk("R9", "stopped v_pos", v_pos, 0);
        chk("R9", "stopped de", de, 0);
        chk("R4", "idle hsync inactive low-active", hsync, 1);
        chk("R4", "idle vsync inactive low-active", vsync, 1);
        fc_hold = frame_cnt;
        repeat (300) step();
        chk("R9", "frame count held while idle", frame_cnt, fc_hold);
        set_cfg_a();
        step();
        chk("R10", "idle follows config", blanked, 0);
        run_en = 1'b1;
        step();
        chk("R9", "restart running", running, 1);
        repeat (14 * 240) step();
        chk("R7", "frame count after wrap", frame_cnt, m_fc);
        finish_run();
    end

endmodule